// File: doc/BRIEF.md
# Entropy Health Monitor and Gate

This block sits between a free-running noise source and a seed conditioner. Raw bits arrive one per accepted cycle and are packed into fixed-width samples. Each sample is graded by a streaming pattern test that looks at the longest run of equal bits and at its population count. A history of the most recent grades gives a rolling count of healthy samples. The block releases nothing until that history has been filled once after reset and the count has cleared its threshold.

Once the source is declared good, samples are gathered in pairs. A pair leaves the block as a double-width seed only when at least two healthy samples have gone into it since the previous seed. Until then, further samples are XOR-folded into the two halves. If the rolling count ever drops below the threshold, the block stops for good and raises a failure flag.

Right after reset, an internal self-test feeds four known patterns through the same grader and compares each grade with its expected result. Any mismatch blocks seeds permanently.

Top module: `entropy_health_gate`

## Requirements
- R1: A bit is taken only in a cycle with `bitValid` high, after the self-test. The first bit taken for a sample becomes its most significant bit.
- R2: A sample is unhealthy when it holds a run of identical bits longer than `MAX_RUN`, or when its count of ones lies outside `ONES_LO`..`ONES_HI` inclusive. Otherwise it is healthy.
- R3: After the history is full, a sample that leaves fewer than `WIN_THRESH` healthy grades among the last `WIN_LEN` samples sets `windowFail`. The flag stays high until reset.
- R4: `sourceReady` stays low until `WIN_LEN` samples have been graded after the self-test. It rises one cycle after the grade of sample number `WIN_LEN` when the healthy count is at least `WIN_THRESH`. It is never high together with `windowFail`.
- R5: For the first 4*`SAMPLE_W` cycles after reset, the grader consumes four internal patterns: alternating bits starting with 1, all ones, zeros then ones in halves, and a one every fourth bit. The expected grades are healthy, unhealthy, unhealthy, unhealthy. `bitIn` and `bitValid` are ignored during this time. A wrong grade sets `startFail`, which stays high until reset.
- R6: While ready, samples go alternately to the upper half and the lower half of the seed, starting with the upper half after each seed. The first write to a half loads the sample. Later writes XOR into it.
- R7: A seed fires on a lower-half write when at least two healthy samples, counting that one, have arrived since the last seed. `seedValid` is then high for one cycle. `seedData` carries {upper, lower}. Bit 1 of `seedTag` marks that the upper half took a healthy sample, and bit 0 does the same for the lower half.
- R8: No seed fires while not ready, after `windowFail` or `startFail`, or on the sample that causes the window failure. Partial pairs are discarded while not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | Raw bit present this cycle |
| bitIn | input | 1 | Raw entropy bit |
| seedValid | output | 1 | One-cycle seed strobe |
| seedData | output | 2*SAMPLE_W | Folded sample pair, upper half first |
| seedTag | output | 2 | Per-half health tag |
| sourceReady | output | 1 | Probation done and source healthy |
| windowFail | output | 1 | Sticky rolling-window failure |
| startFail | output | 1 | Sticky self-test failure |

## Verification
A seed release and a window failure can both come from the same sample: a lower-half write that brings the healthy tally to two and also pushes the rolling count below threshold. The bench provokes this with a directed sequence. It starts from a fully healthy history and a fresh pair, then mixes healthy and unhealthy samples so that the healthy tally reaches two on an upper-half write while the count sits exactly at threshold. A final unhealthy lower-half sample then hits both conditions at once. The bench judges the outcome by seeing no seed strobe at all, `windowFail` high and `sourceReady` low, and it confirms the block stays silent while more healthy samples follow.

// File: rtl/ehm_pkg.sv
package ehm_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic       katMode;   // grader fed by internal patterns
    logic [1:0] katSel;    // which self-test pattern
    logic       accClear;  // drop partial pair
    logic       accWr;     // write current sample into pair
    logic       accSlotB;  // 0: upper half, 1: lower half
    logic       seedFire;  // release the pair with this write
  } ehmCtl_t;
endpackage

// File: rtl/ehm_datapath.sv
module ehm_datapath
  import ehm_pkg::*;
#(
  parameter int SAMPLE_W = 256,
  parameter int MAX_RUN  = 32,
  parameter int ONES_LO  = 96,
  parameter int ONES_HI  = 160
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  bitValid,
  input  logic                  bitIn,
  input  ehmCtl_t               ctl,
  output logic                  sampleStrobe,
  output logic                  sampleHealthy,
  output logic                  seedValid,
  output logic [2*SAMPLE_W-1:0] seedData,
  output logic [1:0]            seedTag
);
  localparam int CNT_W  = $clog2(SAMPLE_W);
  localparam int ONES_W = $clog2(SAMPLE_W + 1);
  localparam int RUN_W  = $clog2(MAX_RUN + 2);
  localparam logic [CNT_W-1:0]  LAST_POS = CNT_W'(SAMPLE_W - 1);
  localparam logic [CNT_W-1:0]  HALF_POS = CNT_W'(SAMPLE_W / 2);
  localparam logic [RUN_W-1:0]  RUN_CAP  = RUN_W'(MAX_RUN + 1);
  localparam logic [RUN_W-1:0]  RUN_MAX  = RUN_W'(MAX_RUN);
  localparam logic [ONES_W-1:0] LO_V     = ONES_W'(ONES_LO);
  localparam logic [ONES_W-1:0] HI_V     = ONES_W'(ONES_HI);

  logic [CNT_W-1:0]    bitCnt;
  logic [SAMPLE_W-1:0] shReg, sampleWord;
  logic [ONES_W-1:0]   onesCnt, onesNext;
  logic [RUN_W-1:0]    runLen, runNext;
  logic                lastBit, runBad, badNext;
  logic                patBit, curBit, takeBit, firstBit;
  logic [SAMPLE_W-1:0] wordNext;

  // self-test pattern generator, position counted from the MSB
  always_comb begin
    case (ctl.katSel)
      2'd0:    patBit = ~bitCnt[0];
      2'd1:    patBit = 1'b1;
      2'd2:    patBit = (bitCnt >= HALF_POS);
      default: patBit = (bitCnt[1:0] == 2'b00);
    endcase
  end

  assign takeBit  = ctl.katMode | bitValid;
  assign curBit   = ctl.katMode ? patBit : bitIn;
  assign firstBit = (bitCnt == '0);
  assign wordNext = {shReg[SAMPLE_W-2:0], curBit};

  // streaming run and population test
  always_comb begin
    if (firstBit || curBit != lastBit) runNext = RUN_W'(1);
    else if (runLen == RUN_CAP)        runNext = RUN_CAP;
    else                               runNext = runLen + RUN_W'(1);
    badNext  = (!firstBit && runBad) || (runNext > RUN_MAX);
    onesNext = (firstBit ? '0 : onesCnt) + ONES_W'(curBit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt        <= '0;
      shReg         <= '0;
      sampleWord    <= '0;
      onesCnt       <= '0;
      runLen        <= '0;
      lastBit       <= 1'b0;
      runBad        <= 1'b0;
      sampleStrobe  <= 1'b0;
      sampleHealthy <= 1'b0;
    end else begin
      sampleStrobe <= 1'b0;
      if (takeBit) begin
        shReg   <= wordNext;
        lastBit <= curBit;
        runLen  <= runNext;
        runBad  <= badNext;
        onesCnt <= onesNext;
        if (bitCnt == LAST_POS) begin
          bitCnt        <= '0;
          sampleWord    <= wordNext;
          sampleHealthy <= !badNext && (onesNext >= LO_V) && (onesNext <= HI_V);
          sampleStrobe  <= 1'b1;
        end else begin
          bitCnt <= bitCnt + CNT_W'(1);
        end
      end
    end
  end

  // pair accumulator with XOR folding
  logic [SAMPLE_W-1:0] slotA, slotB, slotBNext;
  logic                loadedA, loadedB, tagA, tagB, tagBNext;

  assign slotBNext = loadedB ? (slotB ^ sampleWord) : sampleWord;
  assign tagBNext  = (loadedB && tagB) || sampleHealthy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotA     <= '0;
      slotB     <= '0;
      loadedA   <= 1'b0;
      loadedB   <= 1'b0;
      tagA      <= 1'b0;
      tagB      <= 1'b0;
      seedValid <= 1'b0;
      seedData  <= '0;
      seedTag   <= '0;
    end else begin
      seedValid <= 1'b0;
      if (ctl.accClear) begin
        slotA   <= '0;
        slotB   <= '0;
        loadedA <= 1'b0;
        loadedB <= 1'b0;
        tagA    <= 1'b0;
        tagB    <= 1'b0;
      end else if (ctl.accWr) begin
        if (!ctl.accSlotB) begin
          slotA   <= loadedA ? (slotA ^ sampleWord) : sampleWord;
          tagA    <= (loadedA && tagA) || sampleHealthy;
          loadedA <= 1'b1;
        end else if (ctl.seedFire) begin
          seedValid <= 1'b1;
          seedData  <= {slotA, slotBNext};
          seedTag   <= {tagA, tagBNext};
          slotA     <= '0;
          slotB     <= '0;
          loadedA   <= 1'b0;
          loadedB   <= 1'b0;
          tagA      <= 1'b0;
          tagB      <= 1'b0;
        end else begin
          slotB   <= slotBNext;
          tagB    <= tagBNext;
          loadedB <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ehm_control.sv
module ehm_control
  import ehm_pkg::*;
#(
  parameter int SAMPLE_W   = 256,
  parameter int WIN_LEN    = 256,
  parameter int WIN_THRESH = 240
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sampleStrobe,
  input  logic    sampleHealthy,
  output ehmCtl_t ctl,
  output logic    sourceReady,
  output logic    windowFail,
  output logic    startFail
);
  localparam int CNT_W   = $clog2(SAMPLE_W);
  localparam int KAT_CYC = 4 * SAMPLE_W;
  localparam int KC_W    = $clog2(KAT_CYC + 1);
  localparam int WC_W    = $clog2(WIN_LEN + 1);
  localparam logic [KC_W-1:0] KAT_END = KC_W'(KAT_CYC);
  localparam logic [WC_W-1:0] WIN_V   = WC_W'(WIN_LEN);
  localparam logic [WC_W-1:0] TH_V    = WC_W'(WIN_THRESH);

  logic [KC_W-1:0]    katCyc;
  logic [2:0]         katSeen;
  logic [WIN_LEN-1:0] hist;
  logic [WC_W-1:0]    winCnt, cntNext, seenCnt, seenNext;
  logic               ptrB;
  logic [1:0]         hCnt, hNext;
  logic               katPhase, rawStrobe, probDone, failNow, readyNext;

  assign katPhase  = (katSeen != 3'd4);
  assign rawStrobe = sampleStrobe && !katPhase;
  assign cntNext   = winCnt + WC_W'(sampleHealthy) - WC_W'(hist[WIN_LEN-1]);
  assign seenNext  = (seenCnt == WIN_V) ? WIN_V : seenCnt + WC_W'(1);
  assign probDone  = (seenNext == WIN_V);
  assign failNow   = probDone && (cntNext < TH_V);
  assign readyNext = probDone && !failNow && !windowFail && !startFail;
  assign hNext     = (hCnt == 2'd2) ? 2'd2 : hCnt + {1'b0, sampleHealthy};

  always_comb begin
    ctl          = '0;
    ctl.katMode  = (katCyc != KAT_END);
    ctl.katSel   = katCyc[CNT_W+1:CNT_W];
    ctl.accClear = !sourceReady;
    ctl.accWr    = rawStrobe && sourceReady;
    ctl.accSlotB = ptrB;
    ctl.seedFire = rawStrobe && sourceReady && ptrB && (hNext == 2'd2) && !failNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      katCyc      <= '0;
      katSeen     <= '0;
      startFail   <= 1'b0;
      hist        <= '0;
      winCnt      <= '0;
      seenCnt     <= '0;
      windowFail  <= 1'b0;
      sourceReady <= 1'b0;
      ptrB        <= 1'b0;
      hCnt        <= '0;
    end else begin
      if (katCyc != KAT_END) katCyc <= katCyc + KC_W'(1);
      if (sampleStrobe && katPhase) begin
        katSeen <= katSeen + 3'd1;
        if (sampleHealthy != (katSeen == 3'd0)) startFail <= 1'b1;
      end
      if (rawStrobe) begin
        hist        <= {hist[WIN_LEN-2:0], sampleHealthy};
        winCnt      <= cntNext;
        seenCnt     <= seenNext;
        sourceReady <= readyNext;
        if (failNow) windowFail <= 1'b1;
        if (!readyNext || ctl.seedFire) begin
          ptrB <= 1'b0;
          hCnt <= '0;
        end else if (sourceReady) begin
          ptrB <= !ptrB;
          hCnt <= hNext;
        end
      end
    end
  end
endmodule

// File: rtl/entropy_health_gate.sv
module entropy_health_gate
  import ehm_pkg::*;
#(
  parameter int SAMPLE_W   = 256,
  parameter int WIN_LEN    = 256,
  parameter int WIN_THRESH = 240,
  parameter int MAX_RUN    = 32,
  parameter int ONES_LO    = 96,
  parameter int ONES_HI    = 160
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  bitValid,
  input  logic                  bitIn,
  output logic                  seedValid,
  output logic [2*SAMPLE_W-1:0] seedData,
  output logic [1:0]            seedTag,
  output logic                  sourceReady,
  output logic                  windowFail,
  output logic                  startFail
);
  ehmCtl_t ctl;
  logic    sampleStrobe, sampleHealthy;

  ehm_datapath #(
    .SAMPLE_W(SAMPLE_W), .MAX_RUN(MAX_RUN), .ONES_LO(ONES_LO), .ONES_HI(ONES_HI)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn), .ctl(ctl),
    .sampleStrobe(sampleStrobe), .sampleHealthy(sampleHealthy),
    .seedValid(seedValid), .seedData(seedData), .seedTag(seedTag)
  );

  ehm_control #(
    .SAMPLE_W(SAMPLE_W), .WIN_LEN(WIN_LEN), .WIN_THRESH(WIN_THRESH)
  ) i_control (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .sampleHealthy(sampleHealthy),
    .ctl(ctl), .sourceReady(sourceReady), .windowFail(windowFail), .startFail(startFail)
  );
endmodule

// File: rtl/ehm_checker.sv
module ehm_checker (
  input logic       clk,
  input logic       rstN,
  input logic       seedValid,
  input logic [1:0] seedTag,
  input logic       sourceReady,
  input logic       windowFail,
  input logic       startFail
);
  // R8
  seed_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    seedValid |-> (sourceReady && !windowFail && !startFail));
  // R3
  window_fail_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    windowFail |=> windowFail);
  // R5
  start_fail_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    startFail |=> startFail);
  // R4
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    windowFail |-> !sourceReady);
  // R7
  seed_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    seedValid |=> !seedValid);
  // R7
  seed_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    seedValid |-> (seedTag != 2'b00));
endmodule

bind entropy_health_gate ehm_checker i_ehm_checker (
  .clk(clk), .rstN(rstN), .seedValid(seedValid), .seedTag(seedTag),
  .sourceReady(sourceReady), .windowFail(windowFail), .startFail(startFail)
);

// File: tb/test_entropy_health_gate.sv
`timescale 1ns/1ps
module test_entropy_health_gate;
  localparam int SW = 32, WL = 16, TH = 13, MR = 8, LO = 10, HI = 22;

  logic          clk = 1'b0, rstN = 1'b0, bitValid = 1'b0, bitIn = 1'b0;
  logic          seedValid, sourceReady, windowFail, startFail;
  logic [2*SW-1:0] seedData;
  logic [1:0]    seedTag;

  entropy_health_gate #(
    .SAMPLE_W(SW), .WIN_LEN(WL), .WIN_THRESH(TH), .MAX_RUN(MR), .ONES_LO(LO), .ONES_HI(HI)
  ) i_entropy_health_gate (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .seedValid(seedValid), .seedData(seedData), .seedTag(seedTag),
    .sourceReady(sourceReady), .windowFail(windowFail), .startFail(startFail)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;

  // reference model state
  logic [WL-1:0]   mHist = '0;
  int              mCnt = 0, mSeen = 0, mHc = 0;
  bit              mReady = 0, mFailed = 0, mPtrB = 0;
  logic [SW-1:0]   mA = '0, mB = '0;
  bit              mLdA = 0, mLdB = 0, mTagA = 0, mTagB = 0;
  logic [2*SW+1:0] expQ[$];

  function automatic bit isHealthy(logic [SW-1:0] w);
    int ones = 0, run = 0, maxRun = 0;
    logic prev = 1'b0;
    for (int i = SW - 1; i >= 0; i--) begin
      ones += int'(w[i]);
      if (i == SW - 1 || w[i] != prev) run = 1; else run++;
      if (run > maxRun) maxRun = run;
      prev = w[i];
    end
    return (maxRun <= MR) && (ones >= LO) && (ones <= HI);
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clearAcc();
    mA = '0; mB = '0; mLdA = 0; mLdB = 0; mTagA = 0; mTagB = 0; mPtrB = 0; mHc = 0;
  endtask

  task automatic modelApply(logic [SW-1:0] w);
    bit h = isHealthy(w);
    bit failNow;
    mCnt = mCnt + int'(h) - int'(mHist[WL-1]);
    mHist = {mHist[WL-2:0], h};
    if (mSeen < WL) mSeen++;
    failNow = (mSeen == WL) && (mCnt < TH);
    if (mReady) begin
      if (mHc < 2) mHc += int'(h);
      if (!mPtrB) begin
        mA = mLdA ? (mA ^ w) : w;
        mTagA = (mLdA && mTagA) || h;
        mLdA = 1; mPtrB = 1;
      end else begin
        mB = mLdB ? (mB ^ w) : w;
        mTagB = (mLdB && mTagB) || h;
        mLdB = 1; mPtrB = 0;
        if (mHc >= 2 && !failNow) begin
          expQ.push_back({mA, mB, mTagA, mTagB});
          clearAcc();
        end
      end
    end
    if (failNow) mFailed = 1;
    mReady = (mSeen == WL) && !failNow && !mFailed;
    if (!mReady) clearAcc();
  endtask

  // R1: MSB first, idle cycles with garbage on bitIn must be skipped
  task automatic sendWord(logic [SW-1:0] w);
    for (int i = SW - 1; i >= 0; i--) begin
      @(negedge clk);
      if ($urandom_range(0, 5) == 0) begin
        bitValid = 1'b0;
        bitIn = 1'($urandom);
        @(negedge clk);
      end
      bitValid = 1'b1;
      bitIn = w[i];
    end
    @(negedge clk);
    bitValid = 1'b0;
    modelApply(w);
    @(negedge clk);
    chk("R4 sourceReady", 128'(sourceReady), 128'(mReady));
    chk("R3 windowFail", 128'(windowFail), 128'(mFailed));
  endtask

  function automatic logic [SW-1:0] genHealthy();
    logic [SW-1:0] w;
    do w = $urandom; while (!isHealthy(w));
    return w;
  endfunction

  function automatic logic [SW-1:0] genBad();
    case ($urandom_range(0, 3))
      0: return '0;
      1: return '1;
      2: return 32'h0000FFFF;
      default: return 32'h11111111;
    endcase
  endfunction

  // R7 / R8: every seed strobe must match the next modelled seed
  always @(negedge clk) begin
    if (rstN && seedValid) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8 unexpected seed: actual %0h expected none", {seedData, seedTag});
      end else begin
        chk("R7 seed data/tag", 128'({seedData, seedTag}), 128'(expQ.pop_front()));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk("R4 reset sourceReady", 128'(sourceReady), 128'(0));
    chk("R8 reset seedValid", 128'(seedValid), 128'(0));
    chk("R3 reset windowFail", 128'(windowFail), 128'(0));
    chk("R5 reset startFail", 128'(startFail), 128'(0));
    rstN = 1'b1;

    // R5: self-test window, raw input must be ignored
    for (int i = 0; i < 4 * SW - 4; i++) begin
      bitValid = 1'b1;
      bitIn = 1'($urandom);
      @(negedge clk);
    end
    bitValid = 1'b0;
    repeat (12) @(negedge clk);
    chk("R5 self-test startFail", 128'(startFail), 128'(0));
    chk("R4 ready during self-test", 128'(sourceReady), 128'(0));

    // R4: probation of WL healthy samples
    for (int i = 0; i < WL; i++) sendWord(genHealthy());
    chk("R4 ready after probation", 128'(sourceReady), 128'(1));

    // R2 boundaries: run exactly MR, run MR+1, ones at LO, LO-1, HI, HI+1
    sendWord(32'hFF555555);
    sendWord(32'hFFAAAAAA);
    sendWord(32'h11111155);
    sendWord(32'h11111115);
    sendWord(32'hEEEEEEAA);
    sendWord(32'hEEEEEEEA);

    // R6 / R7: constrained random stream keeping the window healthy
    for (int i = 0; i < 120; i++) begin
      if (mCnt >= TH + 2 && $urandom_range(0, 99) < 30) sendWord(genBad());
      else sendWord(genHealthy());
    end

    // R8 coincidence: reach a full healthy window and a fresh pair
    for (int i = 0; i < 60; i++) begin
      if (mCnt == WL && !mPtrB && mHc == 0) break;
      sendWord(genHealthy());
    end
    chk("R6 fresh pair before coincidence", 128'({mCnt, mPtrB, mHc}), 128'({WL, 1'b0, 0}));
    sendWord(32'hFF555555);
    sendWord(32'hFFAAAAAA);
    sendWord(32'h00000000);
    sendWord(32'hFFFFFFFF);
    sendWord(32'h11111155);
    sendWord(32'h0000FFFF);
    repeat (4) @(negedge clk);
    chk("R8 fail on seed-completing sample", 128'({windowFail, sourceReady}), 128'(2'b10));
    chk("R8 no seed pending", 128'(expQ.size()), 128'(0));

    // R3 sticky: healthy samples do not recover the block
    for (int i = 0; i < 4; i++) sendWord(genHealthy());
    repeat (4) @(negedge clk);
    chk("R3 failure sticky", 128'(windowFail), 128'(1));
    chk("R7 all seeds seen", 128'(expQ.size()), 128'(0));
    chk("R5 startFail end", 128'(startFail), 128'(0));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule